// File: doc/BRIEF.md
# Synchronous Byte-Write Static RAM

This block is a single-clock static RAM whose word is split into byte lanes. Address, write data, the three chip selects, the write controls and the output enable are all captured on the rising clock edge. The write itself is then committed from those captured values on the following edge, so the surrounding logic never has to shape a write pulse. A write can cover the whole word through a global write strobe. It can also cover any subset of lanes, through a lane-write enable that qualifies one active-low select per lane.

A mode input picks the read latency. In flow-through mode, the word addressed at edge k is driven right after edge k. In pipelined mode, it passes through a clocked output register and appears after edge k+1. A power-down input acts asynchronously on the output and blocks any access while it is high; the stored contents are kept. The shared data bus is modelled as separate write-data and read-data ports plus a drive flag; a low drive flag stands for a high-impedance bus. The depth and the lane count and width are parameters. The default is kept small (256 words of four 8-bit lanes); a 32K-word array is built by setting `ADDR_W` to 15.

Top module: `sync_bw_sram`

## Requirements
- R1: A cycle is an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at the clock edge. In any other cycle nothing is written, and `rdrive` is 0 at the point where read data would have appeared.
- R2: With `wr_all_n`=0 in a selected cycle, every lane of the addressed word is written, whatever `lane_wr_en_n` and `lane_sel_n` hold.
- R3: With `wr_all_n`=1 and `lane_wr_en_n`=0, exactly the lanes i whose `lane_sel_n[i]` is 0 are written. Lane i is data bits [8i+7:8i]; the other lanes keep their contents.
- R4: A selected cycle is a read, and writes nothing, when `wr_all_n`=1 and either `lane_wr_en_n`=1 or all `lane_sel_n` bits are 1.
- R5: With `out_mode`=0 (flow-through), the word read at edge k is on `rdata` with `rdrive`=1 from edge k until edge k+1.
- R6: With `out_mode`=1 (pipelined), the word read at edge k is on `rdata` with `rdrive`=1 from edge k+1 until edge k+2, and `rdrive` is 0 between edges k and k+1 unless an earlier read is due.
- R7: A read of an address in the cycle right after a write to it returns the newly written word, in both modes.
- R8: `oe_n` is sampled at every edge. `rdrive` can be 1 only when the sample taken at the most recent edge was 0, so a change on `oe_n` reaches the output one edge later, in both modes.
- R9: While `sleep` is 1, `rdrive` is 0 at once, without waiting for a clock edge, and no cycle captured with `sleep`=1 reads or writes. Contents written earlier are still returned after `sleep` falls.
- R10: After reset, `rdrive` is 0 and `rdata` is 0 until a read is due; whenever `rdrive` is 0, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the control registers |
| out_mode | input | 1 | 1 = pipelined output, 0 = flow-through output |
| sleep | input | 1 | Power-down, active high, asynchronous on the output |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, sampled each edge |
| rdata | output | LANES*LANE_W | Read data, 0 when not driven |
| rdrive | output | 1 | 1 when the bus is driven, 0 for high-impedance |

## Verification
The collision that matters most is a write that is still being committed from the captured registers in the same cycle as the read that follows it. The bench issues a write and then a read of the same address on consecutive edges, in both output modes, and expects the new word at the mode's latency. A second overlap is a read that reaches the output in the same cycle as an `oe_n` change or a `sleep` rise. The bench provokes both and judges whether `rdrive` changes at the edge after the change or at once.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_e;

   typedef enum logic {
      OUT_FLOW = 1'b0,
      OUT_PIPE = 1'b1
   } out_mode_e;

   function automatic logic chip_hit(input logic a_n, input logic b, input logic c_n);
      return !a_n && b && !c_n;
   endfunction

endpackage

// File: rtl/sbw_in_stage.sv
module sbw_in_stage
   import sbw_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sleep,
   input  logic                      sel_a_n,
   input  logic                      sel_b,
   input  logic                      sel_c_n,
   input  logic                      wr_all_n,
   input  logic                      lane_wr_en_n,
   input  logic [LANES-1:0]          lane_sel_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic                      oe_n,
   output cyc_e                      cyc_q,
   output logic [LANES-1:0]          mask_q,
   output logic [ADDR_W-1:0]         addr_q,
   output logic [LANES*LANE_W-1:0]   wdata_q,
   output logic                      oe_off_q
);

   localparam int DATA_W = LANES * LANE_W;

   logic             hit;
   logic [LANES-1:0] mask_d;
   cyc_e             cyc_d;

   always_comb begin
      hit = chip_hit(sel_a_n, sel_b, sel_c_n) && !sleep;
      if (!wr_all_n)
         mask_d = '1;
      else if (!lane_wr_en_n)
         mask_d = ~lane_sel_n;
      else
         mask_d = '0;
      if (!hit)
         cyc_d = CYC_IDLE;
      else if (mask_d != '0)
         cyc_d = CYC_WRITE;
      else
         cyc_d = CYC_READ;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q    <= CYC_IDLE;
         mask_q   <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         oe_off_q <= 1'b1;
      end else begin
         cyc_q    <= cyc_d;
         mask_q   <= (cyc_d == CYC_WRITE) ? mask_d : '0;
         addr_q   <= addr;
         wdata_q  <= wdata;
         oe_off_q <= oe_n;
      end
   end

   // R1: a deselected edge captures no access
   a_r1_desel_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !chip_hit(sel_a_n, sel_b, sel_c_n) |=> (cyc_q == CYC_IDLE && mask_q == '0));

   // R2: global write strobe covers every lane
   a_r2_global_all_lanes : assert property (@(posedge clk) disable iff (!rst_n)
      (chip_hit(sel_a_n, sel_b, sel_c_n) && !sleep && !wr_all_n)
      |=> (cyc_q == CYC_WRITE && mask_q == {LANES{1'b1}}));

   // R4: no write strobe of either kind means a read
   a_r4_plain_read : assert property (@(posedge clk) disable iff (!rst_n)
      (chip_hit(sel_a_n, sel_b, sel_c_n) && !sleep && wr_all_n && lane_wr_en_n)
      |=> (cyc_q == CYC_READ && mask_q == '0));

   // R9: nothing is captured while powered down
   a_r9_sleep_no_access : assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (cyc_q == CYC_IDLE));

   logic unused_width;
   assign unused_width = (DATA_W == 0);

endmodule

// File: rtl/sbw_array.sv
module sbw_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                      clk,
   input  logic                      wr_en,
   input  logic [LANES-1:0]          wr_mask,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic [LANES*LANE_W-1:0]   rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_mask[g])
            cells[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[addr];
   end

endmodule

// File: rtl/sbw_out_stage.sv
module sbw_out_stage
   import sbw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  out_mode_e         mode,
   input  logic              sleep,
   input  logic              rd_now,
   input  logic              oe_off_q,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] data_o,
   output logic              drive_o
);

   logic              pipe_v;
   logic [DATA_W-1:0] pipe_d;
   logic              valid;
   logic [DATA_W-1:0] dsel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pipe_v <= 1'b0;
         pipe_d <= '0;
      end else begin
         pipe_v <= rd_now;
         if (rd_now)
            pipe_d <= arr_data;
      end
   end

   always_comb begin
      if (mode == OUT_PIPE) begin
         valid = pipe_v;
         dsel  = pipe_d;
      end else begin
         valid = rd_now;
         dsel  = arr_data;
      end
      drive_o = valid && !oe_off_q && !sleep;
      data_o  = drive_o ? dsel : '0;
   end

   // R9: power-down keeps the bus released
   a_r9_sleep_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !drive_o);

   // R8: the sampled output enable gates the bus
   a_r8_oe_gate : assert property (@(posedge clk) disable iff (!rst_n)
      oe_off_q |-> !drive_o);

   // R6: in pipelined mode the bus carries a read from one edge earlier
   a_r6_pipe_latency : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OUT_PIPE && drive_o) |-> $past(rd_now));

   // R10: undriven bus reads as zero
   a_r10_zero_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !drive_o |-> (data_o == '0));

endmodule

// File: rtl/sync_bw_sram.sv
module sync_bw_sram
   import sbw_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      out_mode,
   input  logic                      sleep,
   input  logic                      sel_a_n,
   input  logic                      sel_b,
   input  logic                      sel_c_n,
   input  logic                      wr_all_n,
   input  logic                      lane_wr_en_n,
   input  logic [LANES-1:0]          lane_sel_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic                      oe_n,
   output logic [LANES*LANE_W-1:0]   rdata,
   output logic                      rdrive
);

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
      $error("sync_bw_sram: ADDR_W must lie in 1..20");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("sync_bw_sram: LANES and LANE_W must be positive");
   end

   cyc_e              cyc_q;
   logic [LANES-1:0]  mask_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              oe_off_q;
   logic [DATA_W-1:0] arr_rd;
   logic              wr_commit;
   logic              rd_now;
   out_mode_e         mode;

   assign mode      = out_mode_e'(out_mode);
   assign wr_commit = (cyc_q == CYC_WRITE) && !sleep;
   assign rd_now    = (cyc_q == CYC_READ);

   sbw_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep        (sleep),
      .sel_a_n      (sel_a_n),
      .sel_b        (sel_b),
      .sel_c_n      (sel_c_n),
      .wr_all_n     (wr_all_n),
      .lane_wr_en_n (lane_wr_en_n),
      .lane_sel_n   (lane_sel_n),
      .addr         (addr),
      .wdata        (wdata),
      .oe_n         (oe_n),
      .cyc_q        (cyc_q),
      .mask_q       (mask_q),
      .addr_q       (addr_q),
      .wdata_q      (wdata_q),
      .oe_off_q     (oe_off_q)
   );

   sbw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk     (clk),
      .wr_en   (wr_commit),
      .wr_mask (mask_q),
      .addr    (addr_q),
      .wdata   (wdata_q),
      .rdata   (arr_rd)
   );

   sbw_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .sleep    (sleep),
      .rd_now   (rd_now),
      .oe_off_q (oe_off_q),
      .arr_data (arr_rd),
      .data_o   (rdata),
      .drive_o  (rdrive)
   );

   // R3: a committed write carries at least one lane
   a_r3_write_has_lane : assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> (mask_q != '0));

endmodule

// File: tb/sync_bw_sram_bench.sv
module sync_bw_sram_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        out_mode = 1'b0;
   logic        sleep = 1'b0;
   logic        sel_a_n, sel_b, sel_c_n;
   logic        wr_all_n, lane_wr_en_n;
   logic [3:0]  lane_sel_n;
   logic [7:0]  addr;
   logic [31:0] wdata;
   logic        oe_n = 1'b0;
   logic [31:0] rdata;
   logic        rdrive;

   int n_checks = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   sync_bw_sram u_sync_bw_sram (
      .clk(clk), .rst_n(rst_n), .out_mode(out_mode), .sleep(sleep),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
      .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdrive(rdrive)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_in();
      sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
      wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF;
      addr = '0; wdata = '0;
   endtask

   task automatic put_write(input logic [7:0] a, input logic [31:0] d,
                            input logic gw, input logic bw, input logic [3:0] be);
      sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
      wr_all_n = gw; lane_wr_en_n = bw; lane_sel_n = be;
      addr = a; wdata = d;
   endtask

   task automatic put_read(input logic [7:0] a);
      sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
      wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF;
      addr = a; wdata = 32'h0BAD_0BAD;
   endtask

   task automatic wr_cycle(input logic [7:0] a, input logic [31:0] d,
                           input logic gw, input logic bw, input logic [3:0] be);
      @(negedge clk); put_write(a, d, gw, bw, be);
      @(negedge clk); idle_in();
   endtask

   task automatic read_expect(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk); put_read(a);
      @(negedge clk); idle_in();
      if (out_mode) @(negedge clk);
      chk({req, " drive"}, {31'd0, rdrive}, 32'd1);
      chk(req, rdata, exp);
   endtask

   task automatic t_reset();
      idle_in();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 drive after reset", {31'd0, rdrive}, 32'd0);
      chk("R10 data after reset", rdata, 32'd0);
   endtask

   task automatic t_global_write();
      wr_cycle(8'h10, 32'hA5A5_1234, 1'b0, 1'b1, 4'hF);
      read_expect(8'h10, 32'hA5A5_1234, "R2 global write, lanes unselected");
      wr_cycle(8'h11, 32'h0F0F_F0F0, 1'b0, 1'b0, 4'b1110);
      read_expect(8'h11, 32'h0F0F_F0F0, "R2 global write overrides lane selects");
   endtask

   task automatic t_lane_write();
      wr_cycle(8'h20, 32'h1122_3344, 1'b0, 1'b1, 4'hF);
      wr_cycle(8'h20, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1010);
      read_expect(8'h20, 32'h11BB_33DD, "R3 lanes 0 and 2");
      wr_cycle(8'h20, 32'h9900_0000, 1'b1, 1'b0, 4'b0111);
      read_expect(8'h20, 32'h99BB_33DD, "R3 lane 3 only");
   endtask

   task automatic t_no_strobe();
      wr_cycle(8'h20, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'h0);
      read_expect(8'h20, 32'h99BB_33DD, "R4 lane selects without enable");
      wr_cycle(8'h20, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'hF);
      read_expect(8'h20, 32'h99BB_33DD, "R4 enable without lane selects");
   endtask

   task automatic t_deselect();
      @(negedge clk); put_write(8'h10, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'hF); sel_a_n = 1'b1;
      @(negedge clk); put_write(8'h10, 32'hEEEE_EEEE, 1'b0, 1'b1, 4'hF); sel_b = 1'b0;
      @(negedge clk); put_write(8'h10, 32'hDDDD_DDDD, 1'b0, 1'b1, 4'hF); sel_c_n = 1'b1;
      @(negedge clk); idle_in();
      read_expect(8'h10, 32'hA5A5_1234, "R1 deselected writes ignored");
      @(negedge clk); put_read(8'h10); sel_b = 1'b0;
      @(negedge clk); idle_in();
      chk("R1 deselected read not driven", {31'd0, rdrive}, 32'd0);
   endtask

   task automatic t_latency();
      @(negedge clk); out_mode = 1'b0; put_read(8'h11);
      @(negedge clk); idle_in();
      chk("R5 flow data after first edge", rdata, 32'h0F0F_F0F0);
      @(negedge clk);
      chk("R5 flow released next cycle", {31'd0, rdrive}, 32'd0);
      out_mode = 1'b1;
      @(negedge clk); put_read(8'h11);
      @(negedge clk); idle_in();
      chk("R6 pipe not yet driven", {31'd0, rdrive}, 32'd0);
      @(negedge clk);
      chk("R6 pipe data after second edge", rdata, 32'h0F0F_F0F0);
      @(negedge clk);
      chk("R6 pipe released", {31'd0, rdrive}, 32'd0);
   endtask

   task automatic t_pass_through(input logic pipe, input logic [31:0] d);
      @(negedge clk); out_mode = pipe; put_write(8'h30, d, 1'b0, 1'b1, 4'hF);
      @(negedge clk); put_read(8'h30);
      @(negedge clk); idle_in();
      if (pipe) @(negedge clk);
      chk("R7 write then read next cycle", rdata, d);
   endtask

   task automatic t_oe();
      @(negedge clk); out_mode = 1'b0; put_read(8'h30); oe_n = 1'b0;
      @(negedge clk); put_read(8'h30); oe_n = 1'b1;
      chk("R8 flow still driven after oe rise", {31'd0, rdrive}, 32'd1);
      @(negedge clk); idle_in();
      chk("R8 flow off one edge later", {31'd0, rdrive}, 32'd0);
      oe_n = 1'b0;
      @(negedge clk); out_mode = 1'b1; put_read(8'h30);
      @(negedge clk); idle_in(); oe_n = 1'b1;
      @(negedge clk);
      chk("R8 pipe gated by oe at output edge", {31'd0, rdrive}, 32'd0);
      oe_n = 1'b0;
   endtask

   task automatic t_sleep();
      @(negedge clk); out_mode = 1'b0; put_read(8'h10);
      @(negedge clk); idle_in();
      chk("R9 driven before sleep", {31'd0, rdrive}, 32'd1);
      sleep = 1'b1;
      #1;
      chk("R9 sleep releases at once", {31'd0, rdrive}, 32'd0);
      @(negedge clk); put_write(8'h10, 32'h1357_9BDF, 1'b0, 1'b1, 4'hF);
      @(negedge clk); put_read(8'h10);
      @(negedge clk); idle_in();
      sleep = 1'b0;
      #1;
      chk("R9 read during sleep not driven", {31'd0, rdrive}, 32'd0);
      read_expect(8'h10, 32'hA5A5_1234, "R9 contents kept, sleep write ignored");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      t_reset();
      t_global_write();
      t_lane_write();
      t_no_strobe();
      t_deselect();
      t_latency();
      t_pass_through(1'b0, 32'hC0DE_0001);
      t_pass_through(1'b1, 32'hC0DE_0002);
      t_oe();
      t_sleep();
      out_mode = 1'b1;
      read_expect(8'h20, 32'h99BB_33DD, "R3 lane data in pipelined mode");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule